// File: doc/BRIEF.md
# Partitioned Ping-Pong Transfer Buffer

This block wraps a single byte-wide buffer RAM that two agents share: a host processor and a USB-side transfer engine. Two length registers, written by the processor, carve the RAM at runtime into three regions. The first is a plain acknowledged-transfer region for control, bulk and interrupt payloads. The other two are isochronous halves of equal size, used in ping-pong fashion. Each agent addresses memory by region and offset. The block maps those to physical addresses and refuses any access that falls outside the programmed region.

The acknowledged region starts at physical address 0. Isochronous half 0 follows it, and half 1 follows half 0. For isochronous traffic the processor always works on the half given by `cpu_half`, and the engine always works on the other half. Both can therefore move isochronous data at the same time.

The processor hands a half over by pulsing `swap_req`. The swap completes when the engine reports that it is idle. A register write that would overflow the RAM is refused, and that refusal is remembered in a sticky flag.

Top module: `xfer_buf_part`

## Requirements
- R1: After reset both length registers read 0, `cfg_err` is 0 and `cpu_half` is 0.
- R2: A register request whose address has bit 7 set is a write. Address 0xAB loads the acknowledged length and 0xAA loads the isochronous half length. With bit 7 clear, address 0x2B returns the acknowledged length and 0x2A returns the half length on `reg_rdata` one cycle later. Any other read address returns 0.
- R3: A length write is accepted only if acknowledged length + 2 × half length ≤ 4096 afterwards. A refused write leaves both registers unchanged and sets the sticky `cfg_err`.
- R4: Region code 0 (`*_iso`=0) maps offset o to physical address o. Region code 1 maps offset o to acknowledged length + h × half length + o, where h is the half in use.
- R5: An access with offset ≥ its region's length raises `*_err` for one cycle in the next cycle. It gives no ack and writes nothing.
- R6: An in-range access raises `*_ack` in the next cycle. For a read, `*_rdata` then holds the byte at the mapped address.
- R7: For isochronous accesses the processor uses half `cpu_half` and the engine uses the opposite half.
- R8: A `swap_req` pulse is remembered until `eng_idle` is high at a clock edge. At that edge `cpu_half` toggles and the request is cleared. A pulse that arrives while `eng_idle` is high toggles at the same edge.
- R9: When both ports hit the same physical address in one cycle, the engine access completes. The processor access gets no ack and must be held; it completes in a later cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_req | input | 1 | Register access strobe |
| reg_addr | input | 8 | Register address, bit 7 = write |
| reg_wdata | input | 13 | Length value to write |
| reg_rdata | output | 13 | Register read data, one cycle after request |
| cfg_err | output | 1 | Sticky refused-partition flag |
| cpu_req | input | 1 | Processor data access request |
| cpu_we | input | 1 | Processor write enable |
| cpu_iso | input | 1 | Processor region: 0 acknowledged, 1 isochronous |
| cpu_off | input | 12 | Processor region offset |
| cpu_wdata | input | 8 | Processor write byte |
| cpu_rdata | output | 8 | Processor read byte |
| cpu_ack | output | 1 | Processor access done |
| cpu_err | output | 1 | Processor access out of range |
| swap_req | input | 1 | Pulse to hand the current half to the engine |
| eng_idle | input | 1 | Engine idle on its current half |
| cpu_half | output | 1 | Isochronous half owned by the processor |
| eng_req | input | 1 | Engine data access request |
| eng_we | input | 1 | Engine write enable |
| eng_iso | input | 1 | Engine region: 0 acknowledged, 1 isochronous |
| eng_off | input | 12 | Engine region offset |
| eng_wdata | input | 8 | Engine write byte |
| eng_rdata | output | 8 | Engine read byte |
| eng_ack | output | 1 | Engine access done |
| eng_err | output | 1 | Engine access out of range |

## Verification
The bench sweeps a grid of length pairs that straddles the 4096-byte limit, including the exact-fit cases. A wrong comparison there would either accept an overflowing layout or refuse a full one, and a missing rollback would leave a half-written illegal partition in the registers. It fills the whole RAM with a known pattern and then reads it back through both ports under several partitions. A wrong base offset or swapped halves would return bytes from the wrong physical location. The last offset of each region and the first offset past it are probed, along with a suppressed out-of-range write. Same-address collisions are checked to confirm the engine wins and the processor retries. Swap requests are made while the engine is busy, to catch a half toggling before the engine has released it.

// File: rtl/xbp_pkg.sv
package xbp_pkg;
    // register index in address bits [6:0]; bit 7 chooses write over read
    localparam logic [6:0] REG_ACK_LEN_IDX = 7'h2B;
    localparam logic [6:0] REG_ISO_LEN_IDX = 7'h2A;

    typedef enum logic {
        RGN_ACK = 1'b0,
        RGN_ISO = 1'b1
    } rgn_e;
endpackage

// File: rtl/xbp_len_regs.sv
module xbp_len_regs
    import xbp_pkg::*;
#(
    parameter int RAM_BYTES = 4096,
    parameter int LEN_W     = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic [7:0]       addr,
    input  logic [LEN_W-1:0] wdata,
    output logic [LEN_W-1:0] rdata,
    output logic [LEN_W-1:0] ack_len,
    output logic [LEN_W-1:0] iso_len,
    output logic             cfg_err
);
    localparam logic [LEN_W+1:0] LIMIT = (LEN_W+2)'(RAM_BYTES);

    typedef struct packed {
        logic [LEN_W-1:0] ack_len;
        logic [LEN_W-1:0] iso_len;
        logic             err;
        logic [LEN_W-1:0] rdata;
    } st_t;

    st_t st_d, st_q;
    logic             wr_hit;
    logic             fits;
    logic [LEN_W-1:0] cand_ack, cand_iso;
    logic [LEN_W+1:0] total;

    always_comb begin
        st_d     = st_q;
        cand_ack = st_q.ack_len;
        cand_iso = st_q.iso_len;
        wr_hit   = 1'b0;
        if (req && addr[7]) begin
            if (addr[6:0] == REG_ACK_LEN_IDX) begin
                cand_ack = wdata;
                wr_hit   = 1'b1;
            end else if (addr[6:0] == REG_ISO_LEN_IDX) begin
                cand_iso = wdata;
                wr_hit   = 1'b1;
            end
        end
        total = {2'b00, cand_ack} + {1'b0, cand_iso, 1'b0};
        fits  = (total <= LIMIT);
        if (wr_hit) begin
            if (fits) begin
                st_d.ack_len = cand_ack;
                st_d.iso_len = cand_iso;
            end else begin
                st_d.err = 1'b1;
            end
        end
        if (req && !addr[7]) begin
            if (addr[6:0] == REG_ACK_LEN_IDX)      st_d.rdata = st_q.ack_len;
            else if (addr[6:0] == REG_ISO_LEN_IDX) st_d.rdata = st_q.iso_len;
            else                                   st_d.rdata = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rdata   = st_q.rdata;
    assign ack_len = st_q.ack_len;
    assign iso_len = st_q.iso_len;
    assign cfg_err = st_q.err;

    // R3
    part_fits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ({2'b00, st_q.ack_len} + {1'b0, st_q.iso_len, 1'b0}) <= LIMIT);
    // R3
    refused_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && !fits) |=> ($stable(st_q.ack_len) && $stable(st_q.iso_len) && st_q.err));
    // R3
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.err |=> st_q.err);
endmodule

// File: rtl/xbp_swap.sv
module xbp_swap (
    input  logic clk,
    input  logic rst_n,
    input  logic swap_req,
    input  logic eng_idle,
    output logic cpu_half
);
    typedef struct packed {
        logic half;
        logic pend;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.pend = st_q.pend | swap_req;
        if (st_d.pend && eng_idle) begin
            st_d.half = ~st_q.half;
            st_d.pend = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cpu_half = st_q.half;

    // R8
    swap_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(st_q.half) |-> $past(eng_idle));
    // R8
    busy_holds_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (swap_req && !eng_idle) |=> (st_q.pend && $stable(st_q.half)));
endmodule

// File: rtl/xbp_xlate.sv
module xbp_xlate
    import xbp_pkg::*;
#(
    parameter int AW    = 12,
    parameter int LEN_W = 13
) (
    input  logic             iso,
    input  logic             half,
    input  logic [AW-1:0]    off,
    input  logic [LEN_W-1:0] ack_len,
    input  logic [LEN_W-1:0] iso_len,
    output logic [AW-1:0]    phys,
    output logic             in_range
);
    logic [LEN_W:0] base;
    logic [LEN_W:0] limit;
    logic [LEN_W:0] sum;
    rgn_e           rgn;

    always_comb begin
        rgn = rgn_e'(iso);
        if (rgn == RGN_ISO) begin
            base  = {1'b0, ack_len} + (half ? {1'b0, iso_len} : '0);
            limit = {1'b0, iso_len};
        end else begin
            base  = '0;
            limit = {1'b0, ack_len};
        end
        sum      = base + (LEN_W+1)'(off);
        phys     = sum[AW-1:0];
        in_range = ((LEN_W+1)'(off) < limit);
    end
endmodule

// File: rtl/xfer_buf_part.sv
module xfer_buf_part
    import xbp_pkg::*;
#(
    parameter int RAM_BYTES = 4096,
    parameter int DW        = 8,
    localparam int AW       = $clog2(RAM_BYTES),
    localparam int LEN_W    = AW + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_req,
    input  logic [7:0]       reg_addr,
    input  logic [LEN_W-1:0] reg_wdata,
    output logic [LEN_W-1:0] reg_rdata,
    output logic             cfg_err,
    input  logic             cpu_req,
    input  logic             cpu_we,
    input  logic             cpu_iso,
    input  logic [AW-1:0]    cpu_off,
    input  logic [DW-1:0]    cpu_wdata,
    output logic [DW-1:0]    cpu_rdata,
    output logic             cpu_ack,
    output logic             cpu_err,
    input  logic             swap_req,
    input  logic             eng_idle,
    output logic             cpu_half,
    input  logic             eng_req,
    input  logic             eng_we,
    input  logic             eng_iso,
    input  logic [AW-1:0]    eng_off,
    input  logic [DW-1:0]    eng_wdata,
    output logic [DW-1:0]    eng_rdata,
    output logic             eng_ack,
    output logic             eng_err
);
    localparam int NPORT = 2;   // 0 = processor, 1 = engine

    logic [LEN_W-1:0] ack_len, iso_len;
    logic             half_w;

    xbp_len_regs #(.RAM_BYTES(RAM_BYTES), .LEN_W(LEN_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .req(reg_req), .addr(reg_addr),
        .wdata(reg_wdata), .rdata(reg_rdata), .ack_len(ack_len),
        .iso_len(iso_len), .cfg_err(cfg_err)
    );

    xbp_swap u_swap (
        .clk(clk), .rst_n(rst_n), .swap_req(swap_req),
        .eng_idle(eng_idle), .cpu_half(half_w)
    );
    assign cpu_half = half_w;

    logic          p_iso   [NPORT];
    logic          p_half  [NPORT];
    logic [AW-1:0] p_off   [NPORT];
    logic [AW-1:0] p_phys  [NPORT];
    logic          p_ok    [NPORT];

    assign p_iso[0]  = cpu_iso;
    assign p_iso[1]  = eng_iso;
    assign p_half[0] = half_w;
    assign p_half[1] = ~half_w;
    assign p_off[0]  = cpu_off;
    assign p_off[1]  = eng_off;

    for (genvar g = 0; g < NPORT; g++) begin : g_xlate
        xbp_xlate #(.AW(AW), .LEN_W(LEN_W)) u_xl (
            .iso(p_iso[g]), .half(p_half[g]), .off(p_off[g]),
            .ack_len(ack_len), .iso_len(iso_len),
            .phys(p_phys[g]), .in_range(p_ok[g])
        );
    end

    typedef struct packed {
        logic cpu_ack;
        logic cpu_err;
        logic eng_ack;
        logic eng_err;
    } st_t;

    st_t  st_d, st_q;
    logic eng_go, cpu_go, clash;

    always_comb begin
        eng_go       = eng_req && p_ok[1];
        clash        = eng_go && cpu_req && p_ok[0] && (p_phys[0] == p_phys[1]);
        cpu_go       = cpu_req && p_ok[0] && !clash;
        st_d.eng_ack = eng_go;
        st_d.eng_err = eng_req && !p_ok[1];
        st_d.cpu_ack = cpu_go;
        st_d.cpu_err = cpu_req && !p_ok[0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    logic [DW-1:0] mem [RAM_BYTES];
    logic [DW-1:0] cpu_rd_q, eng_rd_q;

    always_ff @(posedge clk) begin
        if (eng_go) begin
            eng_rd_q <= mem[p_phys[1]];
            if (eng_we) mem[p_phys[1]] <= eng_wdata;
        end
        if (cpu_go) begin
            cpu_rd_q <= mem[p_phys[0]];
            if (cpu_we) mem[p_phys[0]] <= cpu_wdata;
        end
    end

    assign cpu_rdata = cpu_rd_q;
    assign eng_rdata = eng_rd_q;
    assign cpu_ack   = st_q.cpu_ack;
    assign cpu_err   = st_q.cpu_err;
    assign eng_ack   = st_q.eng_ack;
    assign eng_err   = st_q.eng_err;

    // R5
    cpu_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && !p_ok[0]) |=> (cpu_err && !cpu_ack));
    // R6
    eng_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_req && p_ok[1]) |=> (eng_ack && !eng_err));
    // R7
    halves_apart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_iso && eng_iso && p_ok[0] && p_ok[1]) |-> (p_phys[0] != p_phys[1]));
    // R9
    clash_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && eng_req && p_ok[0] && p_ok[1] && p_phys[0] == p_phys[1])
        |=> (eng_ack && !cpu_ack));
    // R6
    ack_err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(cpu_ack && cpu_err) && !(eng_ack && eng_err));
endmodule

// File: tb/xfer_buf_part_tb.sv
`timescale 1ns/1ps
module xfer_buf_part_tb_top;
    localparam int SZ = 4096;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_req = 0;
    logic [7:0]  reg_addr = 0;
    logic [12:0] reg_wdata = 0;
    logic [12:0] reg_rdata;
    logic        cfg_err;
    logic        cpu_req = 0, cpu_we = 0, cpu_iso = 0;
    logic [11:0] cpu_off = 0;
    logic [7:0]  cpu_wdata = 0, cpu_rdata;
    logic        cpu_ack, cpu_err;
    logic        swap_req = 0, eng_idle = 1, cpu_half;
    logic        eng_req = 0, eng_we = 0, eng_iso = 0;
    logic [11:0] eng_off = 0;
    logic [7:0]  eng_wdata = 0, eng_rdata;
    logic        eng_ack, eng_err;

    int n_chk = 0, n_fail = 0;
    bit done = 0;
    int m_ack = 0, m_iso = 0;
    bit m_err = 0;
    bit m_half = 0;

    always #2.5 clk = ~clk;

    xfer_buf_part dut_i (
        .clk(clk), .rst_n(rst_n), .reg_req(reg_req), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cfg_err(cfg_err),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_iso(cpu_iso), .cpu_off(cpu_off),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_ack(cpu_ack), .cpu_err(cpu_err),
        .swap_req(swap_req), .eng_idle(eng_idle), .cpu_half(cpu_half),
        .eng_req(eng_req), .eng_we(eng_we), .eng_iso(eng_iso), .eng_off(eng_off),
        .eng_wdata(eng_wdata), .eng_rdata(eng_rdata), .eng_ack(eng_ack), .eng_err(eng_err)
    );

    function automatic logic [7:0] pat(int p);
        return 8'(p) ^ 8'(p >> 4) ^ 8'h5A;
    endfunction

    task automatic check(string req, int act, int exp, string what);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic reg_wr(logic [7:0] a, int v);
        @(negedge clk);
        reg_req = 1; reg_addr = a; reg_wdata = 13'(v);
        @(negedge clk);
        reg_req = 0;
    endtask

    task automatic reg_rd(logic [7:0] a, output int v);
        @(negedge clk);
        reg_req = 1; reg_addr = a;
        @(negedge clk);
        reg_req = 0;
        v = int'(reg_rdata);
    endtask

    // bench model of a length write per R3
    task automatic set_len(bit iso, int v);
        int na, ni;
        na = iso ? m_ack : v;
        ni = iso ? v : m_iso;
        reg_wr(iso ? 8'hAA : 8'hAB, v);
        if (na + 2 * ni <= SZ) begin m_ack = na; m_iso = ni; end
        else m_err = 1;
    endtask

    task automatic part(int a, int i);
        set_len(1, 0); set_len(0, 0); set_len(0, a); set_len(1, i);
    endtask

    task automatic cpu_op(bit iso, int off, bit we, logic [7:0] wd,
                          output bit ack, output bit err, output logic [7:0] rd);
        @(negedge clk);
        cpu_req = 1; cpu_iso = iso; cpu_off = 12'(off); cpu_we = we; cpu_wdata = wd;
        @(negedge clk);
        cpu_req = 0; cpu_we = 0;
        ack = cpu_ack; err = cpu_err; rd = cpu_rdata;
    endtask

    task automatic eng_op(bit iso, int off, bit we, logic [7:0] wd,
                          output bit ack, output bit err, output logic [7:0] rd);
        @(negedge clk);
        eng_req = 1; eng_iso = iso; eng_off = 12'(off); eng_we = we; eng_wdata = wd;
        @(negedge clk);
        eng_req = 0; eng_we = 0;
        ack = eng_ack; err = eng_err; rd = eng_rdata;
    endtask

    task automatic probe_map(int a, int i);
        bit ak, er;
        logic [7:0] rd;
        int step;
        part(a, i);
        step = (i / 8 > 0) ? i / 8 : 1;
        for (int o = 0; o < i; o += step) begin
            cpu_op(1, o, 0, 8'h00, ak, er, rd);
            check("R4", rd, pat(a + int'(m_half) * i + o), "cpu iso read");
            eng_op(1, o, 0, 8'h00, ak, er, rd);
            check("R7", rd, pat(a + int'(!m_half) * i + o), "eng iso read");
        end
        if (i > 0) begin
            cpu_op(1, i - 1, 0, 8'h00, ak, er, rd);
            check("R4", rd, pat(a + int'(m_half) * i + i - 1), "cpu iso last byte");
            check("R6", ak, 1, "ack on last byte");
        end
        cpu_op(1, i, 0, 8'h00, ak, er, rd);
        check("R5", {ak, er}, 2'b01, "iso offset at limit");
        if (a > 0) begin
            eng_op(0, a - 1, 0, 8'h00, ak, er, rd);
            check("R4", rd, pat(a - 1), "ack region last byte");
        end
        if (a < SZ) begin
            eng_op(0, a, 0, 8'h00, ak, er, rd);
            check("R5", {ak, er}, 2'b01, "ack offset at limit");
        end
    endtask

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int v;
        bit ak, er, ak2;
        logic [7:0] rd;
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1 reset state
        reg_rd(8'h2B, v); check("R1", v, 0, "ack length after reset");
        reg_rd(8'h2A, v); check("R1", v, 0, "iso length after reset");
        check("R1", cfg_err, 0, "cfg_err after reset");
        check("R1", cpu_half, 0, "cpu_half after reset");
        reg_rd(8'h15, v); check("R2", v, 0, "unknown register");

        // R2 R3 grid sweep across the capacity limit
        for (int a = 0; a <= SZ; a += 256) begin
            for (int i = 0; i <= 2304; i += 256) begin
                part(a, i);
                reg_rd(8'h2B, v); check("R2", v, m_ack, "ack length readback");
                reg_rd(8'h2A, v); check("R3", v, m_iso, "iso length after write");
                check("R3", cfg_err, m_err, "sticky error");
            end
        end
        part(0, 1024);
        set_len(0, 2304);
        reg_rd(8'h2B, v); check("R3", v, 0, "refused ack write keeps value");
        set_len(0, 2048);
        reg_rd(8'h2B, v); check("R3", v, 2048, "exact fit 800/400 accepted");
        set_len(1, 13'h1FFF);
        reg_rd(8'h2A, v); check("R3", v, 1024, "oversized value refused");
        check("R3", cfg_err, 1, "error flag sticky");

        // R6 fill whole RAM through the ack region, read back through engine
        part(SZ, 0);
        for (int p = 0; p < SZ; p++) cpu_op(0, p, 1, pat(p), ak, er, rd);
        for (int p = 0; p < SZ; p++) begin
            eng_op(0, p, 0, 8'h00, ak, er, rd);
            if (rd != pat(p) || !ak) check("R6", rd, pat(p), "engine readback");
        end
        n_chk++;

        // R4 R5 R7 mapping under several partitions
        probe_map(256, 128);
        probe_map(2048, 1024);
        probe_map(32, 2032);
        probe_map(1024, 512);

        // R5 suppressed out-of-range write
        part(256, 128);
        cpu_op(1, 128, 1, 8'hEE, ak, er, rd);
        check("R5", {ak, er}, 2'b01, "out of range write flagged");
        eng_op(1, 0, 0, 8'h00, ak, er, rd);
        check("R5", rd, pat(256 + 128), "out of range write suppressed");

        // R8 swap waits for engine idle
        @(negedge clk); eng_idle = 0; swap_req = 1;
        @(negedge clk); swap_req = 0;
        check("R8", cpu_half, m_half, "no swap while busy");
        repeat (3) @(negedge clk);
        check("R8", cpu_half, m_half, "still held while busy");
        eng_idle = 1; m_half = !m_half;
        @(negedge clk);
        check("R8", cpu_half, m_half, "swap once idle");
        @(negedge clk);
        check("R8", cpu_half, m_half, "single toggle");
        swap_req = 1; m_half = !m_half;
        @(negedge clk); swap_req = 0;
        check("R8", cpu_half, m_half, "immediate swap when idle");

        // R7 ping-pong hand-over
        cpu_op(1, 5, 1, 8'hA5, ak, er, rd);
        @(negedge clk); swap_req = 1; m_half = !m_half;
        @(negedge clk); swap_req = 0;
        eng_op(1, 5, 0, 8'h00, ak, er, rd);
        check("R7", rd, 8'hA5, "engine sees handed-over half");
        check("R7", cpu_half, m_half, "half after handover");

        // R9 same-address collision
        @(negedge clk);
        cpu_req = 1; cpu_iso = 0; cpu_off = 12'h10; cpu_we = 1; cpu_wdata = 8'h3C;
        eng_req = 1; eng_iso = 0; eng_off = 12'h10; eng_we = 0;
        @(negedge clk);
        check("R9", eng_ack, 1, "engine wins collision");
        check("R9", cpu_ack, 0, "processor stalled");
        check("R9", eng_rdata, pat(16), "engine read old byte");
        eng_req = 0;
        @(negedge clk);
        ak2 = cpu_ack;
        cpu_req = 0; cpu_we = 0;
        check("R9", ak2, 1, "processor completes after stall");
        eng_op(0, 16, 0, 8'h00, ak, er, rd);
        check("R9", rd, 8'h3C, "stalled write landed");

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule